// File: doc/BRIEF.md
# Hot-Insert Bus Connection Sequencer

This block decides when the backplane segment and the card segment of a two-wire serial bus may be tied together on a card that is inserted into a live system. It owns the control side only. The pass element, the precharge source, the rise-time accelerators and the stuck-bus watchdog all sit outside. The block drives their enables and a ready status, and it takes the watchdog's fault flag as an input.

After the supply is declared good, the sequencer waits for a safe moment on the bus before it joins the two segments. A safe moment is either both segments idle, or one segment closing a transfer with a stop while the other is idle. Precharge is retired at the first join and stays off until the supply is lost again. Dropping the enable input isolates the card. When enable comes back, the sequencer waits for a safe moment again. A stuck fault reported by the watchdog also isolates the card. A fresh rising edge on enable during a fault forces the segments back together at once and asks the watchdog to restart its timer.

Top module: `hot_insert_seq`

## Requirements
- R1: While `supply_ok` is low, `connect` is low and `precharge_en` is high from the next clock on. Bus activity seen during this time is discarded: stop and idle history starts afresh when the supply returns.
- R2: With the supply good and enable high, the segments are joined only when one of these holds: both sides are idle; the upstream side shows a stop while the downstream side is idle; the downstream side shows a stop while the upstream side is idle. A stop is SDA going 0 to 1 while SCL was and is 1. Idle is SDA and SCL both 1 for `IDLE_CYC` consecutive synchronized samples.
- R3: `precharge_en` goes low when the segments are first joined. It stays low until `supply_ok` is seen low.
- R4: Enable low disconnects the segments. After enable returns high, the segments are joined again only after a new R2 qualification.
- R5: `ready` is high exactly when the synchronized enable is high and the segments are joined.
- R6: `accel_en` is high only after precharge has been retired, and it is low one clock after `recov_active` is seen high.
- R7: A rising edge of `stuck_fault` while joined disconnects the segments and drops `ready`. Once `stuck_fault` clears, the block waits for an R2 qualification before it joins again.
- R8: A rising edge of the synchronized enable while in fault joins the segments at once, even if `stuck_fault` is still high, and pulses `wd_restart` high for one clock.
- R9: `en_in` passes through a two-flop synchronizer. When `en_in` falls, `ready` is still high after the first rising clock edge and is low after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above lockout threshold |
| en_in | input | 1 | Connection enable, asynchronous |
| up_sda | input | 1 | Backplane data line level |
| up_scl | input | 1 | Backplane clock line level |
| dn_sda | input | 1 | Card data line level |
| dn_scl | input | 1 | Card clock line level |
| stuck_fault | input | 1 | Bus-stuck flag from the watchdog |
| recov_active | input | 1 | Automatic recovery clocking in progress |
| connect | output | 1 | Enable of the segment pass element |
| precharge_en | output | 1 | Enable of the precharge source |
| accel_en | output | 1 | Enable of the rise-time accelerators |
| ready | output | 1 | Segments joined and enabled |
| wd_restart | output | 1 | One-clock request to restart the stuck timer |

## Verification
The hardest case to reach is a qualification that rests on a stop seen on one side while the other side is already idle. The stop side must not itself count as idle when the decision is taken. The stimulus parks each side in one of three states while enable is low: idle, SCL high with SDA low, or SCL low. It then raises enable and afterwards raises SDA on every side parked for a stop. The outcome is sampled well before `IDLE_CYC` samples could make the stop side idle. All nine side combinations are swept. The forced reconnect is reached by raising a fault while joined, lowering enable, and raising it again with the fault still present.

// File: rtl/hisq_pkg.sv
package hisq_pkg;

    typedef enum logic [1:0] {
        ST_LOCKOUT   = 2'd0,
        ST_WAIT_QUAL = 2'd1,
        ST_CONNECTED = 2'd2,
        ST_FAULT     = 2'd3
    } seq_state_e;

    // per-side bus condition seen by the monitors
    typedef struct packed {
        logic stop;
        logic idle;
    } side_cond_t;

    localparam int NSIDES = 2;
    localparam int SIDE_UP = 0;
    localparam int SIDE_DN = 1;

    // safe moment to join: idle/idle, or a stop on one side with the other idle
    function automatic logic join_ok(side_cond_t a, side_cond_t b);
        return (a.idle && b.idle) || (a.stop && b.idle) || (b.stop && a.idle);
    endfunction

endpackage

// File: rtl/hisq_sync.sv
module hisq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hisq_side_mon.sv
module hisq_side_mon
    import hisq_pkg::*;
#(
    parameter int IDLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       sda_s,
    input  logic       scl_s,
    output side_cond_t cond
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(IDLE_CYC);

    logic          sda_q;
    logic          scl_q;
    logic [CW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sda_q    <= 1'b0;
            scl_q    <= 1'b0;
            high_cnt <= '0;
        end else begin
            sda_q <= sda_s;
            scl_q <= scl_s;
            if (!(sda_s && scl_s))
                high_cnt <= '0;
            else if (high_cnt != CMAX)
                high_cnt <= high_cnt + 1'b1;
        end
    end

    always_comb begin
        cond.stop = !clr && sda_s && !sda_q && scl_s && scl_q;
        cond.idle = !clr && (high_cnt == CMAX);
    end
endmodule

// File: rtl/hisq_fsm.sv
module hisq_fsm
    import hisq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic en_s,
    input  logic qual,
    input  logic stuck_fault,
    input  logic recov_active,
    output logic connect,
    output logic precharge_en,
    output logic accel_en,
    output logic ready,
    output logic wd_restart
);
    seq_state_e state, state_nx;
    logic en_q;
    logic stuck_q;
    logic recov_q;
    logic pc_retired;
    logic en_rise;
    logic stuck_rise;

    assign en_rise    = en_s && !en_q;
    assign stuck_rise = stuck_fault && !stuck_q;

    always_comb begin
        state_nx = state;
        if (!supply_ok) begin
            state_nx = ST_LOCKOUT;
        end else begin
            unique case (state)
                ST_LOCKOUT:   state_nx = ST_WAIT_QUAL;
                ST_WAIT_QUAL: if (en_s && qual) state_nx = ST_CONNECTED;
                ST_CONNECTED: begin
                    if (stuck_rise)  state_nx = ST_FAULT;
                    else if (!en_s)  state_nx = ST_WAIT_QUAL;
                end
                ST_FAULT: begin
                    if (en_rise)           state_nx = ST_CONNECTED;
                    else if (!stuck_fault) state_nx = ST_WAIT_QUAL;
                end
                default: state_nx = ST_LOCKOUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_LOCKOUT;
            en_q       <= 1'b0;
            stuck_q    <= 1'b0;
            recov_q    <= 1'b0;
            pc_retired <= 1'b0;
            wd_restart <= 1'b0;
        end else begin
            state      <= state_nx;
            en_q       <= en_s;
            stuck_q    <= stuck_fault;
            recov_q    <= recov_active;
            wd_restart <= supply_ok && (state == ST_FAULT) && en_rise;
            if (!supply_ok)
                pc_retired <= 1'b0;
            else if (state_nx == ST_CONNECTED)
                pc_retired <= 1'b1;
        end
    end

    always_comb begin
        connect      = (state == ST_CONNECTED);
        ready        = connect && en_s;
        precharge_en = !pc_retired;
        accel_en     = pc_retired && !recov_q;
    end
endmodule

// File: rtl/hot_insert_seq.sv
module hot_insert_seq
    import hisq_pkg::*;
#(
    parameter int IDLE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic en_in,
    input  logic up_sda,
    input  logic up_scl,
    input  logic dn_sda,
    input  logic dn_scl,
    input  logic stuck_fault,
    input  logic recov_active,
    output logic connect,
    output logic precharge_en,
    output logic accel_en,
    output logic ready,
    output logic wd_restart
);
    localparam int SW = 1 + 2 * NSIDES;

    logic [SW-1:0]     raw_in;
    logic [SW-1:0]     syn_in;
    logic              en_s;
    logic [NSIDES-1:0] sda_s;
    logic [NSIDES-1:0] scl_s;
    side_cond_t        cond [NSIDES];
    logic              qual;

    assign raw_in = {en_in, dn_scl, dn_sda, up_scl, up_sda};

    hisq_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign en_s = syn_in[SW-1];

    for (genvar s = 0; s < NSIDES; s++) begin : g_side
        assign sda_s[s] = syn_in[2*s];
        assign scl_s[s] = syn_in[2*s+1];

        hisq_side_mon #(.IDLE_CYC(IDLE_CYC)) u_mon (
            .clk   (clk),
            .rst   (rst),
            .clr   (!supply_ok),
            .sda_s (sda_s[s]),
            .scl_s (scl_s[s]),
            .cond  (cond[s])
        );
    end

    assign qual = join_ok(cond[SIDE_UP], cond[SIDE_DN]);

    hisq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .supply_ok    (supply_ok),
        .en_s         (en_s),
        .qual         (qual),
        .stuck_fault  (stuck_fault),
        .recov_active (recov_active),
        .connect      (connect),
        .precharge_en (precharge_en),
        .accel_en     (accel_en),
        .ready        (ready),
        .wd_restart   (wd_restart)
    );
endmodule

// File: rtl/hot_insert_seq_chk.sv
module hot_insert_seq_chk (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic en_in,
    input logic up_sda,
    input logic up_scl,
    input logic dn_sda,
    input logic dn_scl,
    input logic stuck_fault,
    input logic recov_active,
    input logic connect,
    input logic precharge_en,
    input logic accel_en,
    input logic ready,
    input logic wd_restart
);
    // R1: lockout isolates and precharges
    assert_lockout_R1: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (!connect && precharge_en));

    // R3: joined implies precharge retired
    assert_pc_off_R3: assert property (@(posedge clk) disable iff (rst)
        connect |-> !precharge_en);

    // R3: retirement holds while supply stays good
    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!precharge_en && supply_ok) |=> !precharge_en);

    // R5: ready never without a join
    assert_ready_R5: assert property (@(posedge clk) disable iff (rst)
        ready |-> connect);

    // R6: accelerators only after retirement
    assert_accel_R6: assert property (@(posedge clk) disable iff (rst)
        accel_en |-> !precharge_en);

    // R6: recovery clocking switches accelerators off
    assert_accel_recov_R6: assert property (@(posedge clk) disable iff (rst)
        recov_active |=> !accel_en);

    // R8: restart pulse comes with a forced join and lasts one clock
    assert_override_R8: assert property (@(posedge clk) disable iff (rst)
        wd_restart |-> (connect && !$past(connect)));

    assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        wd_restart |=> !wd_restart);
endmodule

bind hot_insert_seq hot_insert_seq_chk u_chk (.*);

// File: tb/hot_insert_seq_test.sv
module hot_insert_seq_test;
    localparam int IDLE = 6;

    logic clk = 1'b0;
    logic rst, supply_ok, en_in, up_sda, up_scl, dn_sda, dn_scl;
    logic stuck_fault, recov_active;
    logic connect, precharge_en, accel_en, ready, wd_restart;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    always #5 clk = ~clk;

    hot_insert_seq #(.IDLE_CYC(IDLE)) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .en_in(en_in),
        .up_sda(up_sda), .up_scl(up_scl), .dn_sda(dn_sda), .dn_scl(dn_scl),
        .stuck_fault(stuck_fault), .recov_active(recov_active),
        .connect(connect), .precharge_en(precharge_en), .accel_en(accel_en),
        .ready(ready), .wd_restart(wd_restart)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    // side pattern: 0 idle, 1 parked for stop, 2 busy
    task automatic park(input int u, input int d);
        up_scl = (u != 2); up_sda = (u == 0);
        dn_scl = (d != 2); dn_sda = (d == 0);
    endtask

    initial begin
        rst = 1; supply_ok = 0; en_in = 0; stuck_fault = 0; recov_active = 0;
        park(0, 0);
        cyc(3);
        rst = 0;
        cyc(2);
        check("R1", "reset connect", connect, 1'b0);
        check("R5", "reset ready", ready, 1'b0);
        check("R1", "reset precharge", precharge_en, 1'b1);
        check("R6", "reset accel", accel_en, 1'b0);
        check("R8", "reset restart", wd_restart, 1'b0);

        // R1: enable and idle bus during lockout
        en_in = 1;
        cyc(20);
        check("R1", "lockout connect", connect, 1'b0);
        check("R1", "lockout precharge", precharge_en, 1'b1);

        // R2/R3/R5/R6: first join on idle/idle
        supply_ok = 1;
        cyc(IDLE + 8);
        check("R2", "idle join", connect, 1'b1);
        check("R3", "precharge retired", precharge_en, 1'b0);
        check("R5", "ready joined", ready, 1'b1);
        check("R6", "accel on", accel_en, 1'b1);

        // R9: synchronizer latency on enable fall
        en_in = 0;
        cyc(1);
        check("R9", "ready after 1 edge", ready, 1'b1);
        cyc(1);
        check("R9", "ready after 2 edges", ready, 1'b0);
        cyc(2);
        check("R4", "enable low disconnect", connect, 1'b0);
        check("R3", "precharge stays off", precharge_en, 1'b0);

        // R2/R4: sweep every side combination
        for (int u = 0; u < 3; u++) begin
            for (int d = 0; d < 3; d++) begin
                logic exp;
                en_in = 0;
                cyc(4);
                park(u, d);
                cyc(IDLE + 4);
                check("R4", "disconnected before qual", connect, 1'b0);
                en_in = 1;
                cyc(4);
                if (u == 1) up_sda = 1;
                if (d == 1) dn_sda = 1;
                cyc(4);
                exp = (u != 2) && (d != 2) && !(u == 1 && d == 1);
                check("R2", $sformatf("sweep up=%0d dn=%0d", u, d), connect, exp);
            end
        end

        // R7: fault while joined
        en_in = 0; cyc(4);
        park(0, 0); cyc(IDLE + 4);
        en_in = 1; cyc(4);
        check("R7", "joined before fault", connect, 1'b1);
        stuck_fault = 1; recov_active = 1; dn_scl = 0;
        cyc(3);
        check("R7", "fault disconnect", connect, 1'b0);
        check("R7", "fault ready", ready, 1'b0);
        check("R6", "accel off in recovery", accel_en, 1'b0);
        stuck_fault = 0; recov_active = 0;
        cyc(6);
        check("R7", "no join while busy", connect, 1'b0);
        check("R6", "accel back", accel_en, 1'b1);
        dn_scl = 1;
        cyc(IDLE + 6);
        check("R7", "rejoin after release", connect, 1'b1);

        // R8: forced join while fault persists
        stuck_fault = 1;
        cyc(4);
        check("R8", "in fault", connect, 1'b0);
        en_in = 0;
        cyc(4);
        check("R8", "fault holds with enable low", connect, 1'b0);
        en_in = 1;
        cyc(2);
        check("R8", "not yet forced", connect, 1'b0);
        cyc(1);
        check("R8", "forced join", connect, 1'b1);
        check("R8", "restart pulse", wd_restart, 1'b1);
        cyc(1);
        check("R8", "restart ends", wd_restart, 1'b0);
        check("R8", "stays joined", connect, 1'b1);
        check("R5", "ready after force", ready, 1'b1);

        // R1/R3: supply loss re-arms precharge; history restarts
        supply_ok = 0;
        cyc(1);
        check("R1", "supply loss disconnect", connect, 1'b0);
        check("R3", "precharge re-armed", precharge_en, 1'b1);
        stuck_fault = 0;
        cyc(3);
        supply_ok = 1;
        cyc(3);
        check("R1", "idle history restarted", connect, 1'b0);
        check("R3", "precharge before join", precharge_en, 1'b1);
        cyc(IDLE + 4);
        check("R2", "join after supply back", connect, 1'b1);
        check("R3", "retired again", precharge_en, 1'b0);

        finish_run();
    end
endmodule